// File: doc/BRIEF.md
# Dual-Mode Oversampling Baud Tick Generator

This block turns the system clock into the timing strobes of an asynchronous serial port: a single-cycle oversample strobe at sixteen times the bit rate, and a bit strobe on every sixteenth oversample strobe. A 13-bit down-counter sets the division. It is fed either by a fixed clock prescaler of two or three, or by a 9-bit fractional accumulator whose carry output fires on average fdv/512 of the clock cycles.

Software drives the block through three write ports. The control write carries the run bit, the prescaler select bit and the fractional-mode bit. The other two writes set the reload value and the fractional step. The reload value and the step can change only while the generator is stopped. Both read back on their own outputs. Setting the run bit restarts all counting state, so the first strobe comes exactly one period after the starting write.

Top module: `baud_tick_gen`

## Requirements
- R1: A reload write (`rld_we`) while the generator is stopped stores the 13-bit value (0 to 8191), and `cur_reload` shows it after the next clock edge. Reset value is 0.
- R2: A reload write while the generator runs is ignored. `cur_reload` and the strobe period stay unchanged.
- R3: With `ctl_frac`=0, the oversample strobe fires every P×(reload+1) clocks. P is 2 when the prescaler select bit is 0 and 3 when it is 1.
- R4: With `ctl_frac`=1, the step fdv is added to a 9-bit accumulator on every clock. Each carry out decrements the reload counter. The n-th oversample strobe comes ceil(n×(reload+1)×512/fdv) clocks after the starting write edge.
- R5: A step write (`fdv_we`) stores the 9-bit value only while the generator is stopped and is shown on `cur_fdv`. While the generator runs, the write is ignored.
- R6: `bit_tick` pulses together with every sixteenth `ovs_tick` and at no other time. The first `bit_tick` coincides with the sixteenth oversample strobe after a start.
- R7: A control write that sets the run bit while the generator is stopped reloads the counter and clears the prescaler, the accumulator and the divide-by-16 state. The k-th strobe comes k periods after that write's clock edge.
- R8: A control write with the run bit at 0 stops the generator. From the following cycle on, no strobe is emitted.
- R9: After reset, both strobes are low, the generator is stopped, and `cur_reload` and `cur_fdv` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run bit (1 starts, 0 stops) |
| ctl_pre3 | input | 1 | Prescaler select: 0 selects /2, 1 selects /3 |
| ctl_frac | input | 1 | 1 selects the fractional accumulator path |
| rld_we | input | 1 | Reload value write strobe |
| rld_val | input | 13 | Reload value |
| fdv_we | input | 1 | Fractional step write strobe |
| fdv_val | input | 9 | Fractional step |
| ovs_tick | output | 1 | Single-cycle oversample strobe |
| bit_tick | output | 1 | Single-cycle bit-rate strobe |
| cur_reload | output | 13 | Stored reload value |
| cur_fdv | output | 9 | Stored fractional step |

## Verification
The embedded assertions check the following on every cycle:
- the reload value and the step hold steady whenever the generator was already running;
- no strobe appears while the generator is stopped;
- a bit strobe never appears without an oversample strobe;
- a start leaves the prescaler, the accumulator and the divider cleared;
- the prescaler stays in range.

The exact strobe positions can only be shown by the bench's scenarios. These cover the fixed and fractional periods, the first-strobe timing after a start, the sixteen-to-one spacing of the bit strobe, and the rejection of writes during a run. The bench compares each of these against closed-form edge counts over random and extreme reload and step values.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int RLD_W  = 13,
  parameter int FRAC_W = 9,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_run,
  input  logic              ctl_pre3,
  input  logic              ctl_frac,
  input  logic              rld_we,
  input  logic [RLD_W-1:0]  rld_val,
  input  logic              fdv_we,
  input  logic [FRAC_W-1:0] fdv_val,
  output logic              ovs_tick,
  output logic              bit_tick,
  output logic [RLD_W-1:0]  cur_reload,
  output logic [FRAC_W-1:0] cur_fdv
);
  localparam int DIV_W = (OVS > 1) ? $clog2(OVS) : 1;

  logic              run_q, pre3_q, frac_q;
  logic [RLD_W-1:0]  reload_q, cnt_q;
  logic [FRAC_W-1:0] fdv_q, acc_q;
  logic [1:0]        pre_q;
  logic [DIV_W-1:0]  div_q;
  logic              ovs_q, bit_q;

  wire              start   = ctl_we & ctl_run & ~run_q;
  wire              rld_ok  = rld_we & ~run_q;
  wire              fdv_ok  = fdv_we & ~run_q;
  wire [RLD_W-1:0]  rld_nx  = rld_ok ? rld_val : reload_q;
  wire [FRAC_W:0]   acc_sum = {1'b0, acc_q} + {1'b0, fdv_q};
  wire [1:0]        pre_lim = pre3_q ? 2'd2 : 2'd1;
  wire              en_fix  = (pre_q == pre_lim);
  wire              en      = run_q & (frac_q ? acc_sum[FRAC_W] : en_fix);
  wire              hit     = en & (cnt_q == '0);
  wire              div_end = (div_q == DIV_W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      pre3_q   <= 1'b0;
      frac_q   <= 1'b0;
      reload_q <= '0;
      fdv_q    <= '0;
    end else begin
      if (ctl_we) begin
        run_q  <= ctl_run;
        pre3_q <= ctl_pre3;
        frac_q <= ctl_frac;
      end
      reload_q <= rld_nx;
      if (fdv_ok) fdv_q <= fdv_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      acc_q <= '0;
      cnt_q <= '0;
      div_q <= '0;
      ovs_q <= 1'b0;
      bit_q <= 1'b0;
    end else if (start) begin
      pre_q <= '0;
      acc_q <= '0;
      cnt_q <= rld_nx;
      div_q <= '0;
      ovs_q <= 1'b0;
      bit_q <= 1'b0;
    end else if (run_q) begin
      if (!frac_q) pre_q <= en_fix ? 2'd0 : pre_q + 2'd1;
      else         acc_q <= acc_sum[FRAC_W-1:0];
      if (en) cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
      if (hit) div_q <= div_end ? '0 : div_q + 1'b1;
      ovs_q <= hit;
      bit_q <= hit & div_end;
    end else begin
      ovs_q <= 1'b0;
      bit_q <= 1'b0;
    end
  end

  assign ovs_tick   = ovs_q;
  assign bit_tick   = bit_q;
  assign cur_reload = reload_q;
  assign cur_fdv    = fdv_q;

  a_r2_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q) |-> $stable(reload_q));
  a_r5_fdv_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q) |-> $stable(fdv_q));
  a_r8_silent_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !ovs_tick && !bit_tick);
  a_r6_bit_with_ovs: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> ovs_tick);
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (pre_q == '0) && (acc_q == '0) && (div_q == '0) && !ovs_tick);
  a_r3_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= 2'd2);
endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, ctl_run = 0, ctl_pre3 = 0, ctl_frac = 0;
  logic rld_we = 0, fdv_we = 0;
  logic [12:0] rld_val = '0;
  logic [8:0]  fdv_val = '0;
  logic ovs_tick, bit_tick;
  logic [12:0] cur_reload;
  logic [8:0]  cur_fdv;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_run(ctl_run),
    .ctl_pre3(ctl_pre3), .ctl_frac(ctl_frac), .rld_we(rld_we), .rld_val(rld_val),
    .fdv_we(fdv_we), .fdv_val(fdv_val), .ovs_tick(ovs_tick), .bit_tick(bit_tick),
    .cur_reload(cur_reload), .cur_fdv(cur_fdv));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_edge(input bit frac, input bit p3, input int r,
                                      input int fdv, input int n);
    if (frac) return (longint'(n) * (r + 1) * 512 + fdv - 1) / fdv;
    return longint'(n) * (p3 ? 3 : 2) * (r + 1);
  endfunction

  task automatic ctl(input bit run, input bit p3, input bit frac);
    @(negedge clk);
    ctl_we = 1; ctl_run = run; ctl_pre3 = p3; ctl_frac = frac;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic program_regs(input int r, input int fdv);
    @(negedge clk);
    rld_we = 1; rld_val = 13'(r); fdv_we = 1; fdv_val = 9'(fdv);
    @(negedge clk);
    rld_we = 0; fdv_we = 0;
  endtask

  // Start and observe; start write edge is edge 0. Optionally poke registers while running.
  task automatic run_case(input bit frac, input bit p3, input int r, input int fdv,
                          input bit poke, input bit full);
    longint e1 = exp_edge(frac, p3, r, fdv, 1);
    longint e2 = exp_edge(frac, p3, r, fdv, 2);
    longint e16 = exp_edge(frac, p3, r, fdv, 16);
    longint lim = full ? e16 + 4 : e1 + 2;
    longint f1 = -1, f2 = -1, fb = -1;
    int novs = 0;
    ctl(1'b0, p3, frac);
    program_regs(r, fdv);
    @(negedge clk);
    ctl_we = 1; ctl_run = 1; ctl_pre3 = p3; ctl_frac = frac;
    @(posedge clk);
    @(negedge clk);
    ctl_we = 0;
    for (longint k = 1; k <= lim; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (ovs_tick) begin
        novs++;
        if (f1 < 0) f1 = k; else if (f2 < 0) f2 = k;
      end
      if (bit_tick && fb < 0) begin
        fb = k;
        chk(novs == 16, "R6 ovs count at first bit tick", novs, 16);
      end
      if (poke && k == 1) begin
        rld_we = 1; rld_val = 13'(r + 5); fdv_we = 1; fdv_val = 9'(fdv ^ 9'h0ff);
      end else begin
        rld_we = 0; fdv_we = 0;
      end
    end
    rld_we = 0; fdv_we = 0;
    if (frac) chk(f1 == e1, "R4 first fractional tick edge", f1, e1);
    else      chk(f1 == e1, "R3 first fixed tick edge (R7 start timing)", f1, e1);
    if (full) begin
      chk(f2 == e2, "R7 second tick edge", f2, e2);
      chk(fb == e16, "R6 first bit tick edge", fb, e16);
    end
    if (poke) begin
      chk(cur_reload == 13'(r), "R2 reload held while running", cur_reload, r);
      chk(cur_fdv == 9'(fdv), "R5 fdv held while running", cur_fdv, fdv);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(ovs_tick == 0 && bit_tick == 0, "R9 reset strobes", ovs_tick, 0);
    chk(cur_reload == 0, "R9 reset reload", cur_reload, 0);
    chk(cur_fdv == 0, "R9 reset fdv", cur_fdv, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    program_regs(1234, 77);
    chk(cur_reload == 13'd1234, "R1 reload write when stopped", cur_reload, 1234);
    chk(cur_fdv == 9'd77, "R5 fdv write when stopped", cur_fdv, 77);
    run_case(0, 0, 0, 1, 0, 1);
    run_case(0, 1, 0, 1, 0, 1);
    run_case(0, 0, 7, 1, 1, 1);
    run_case(0, 1, 5, 1, 0, 1);
    run_case(1, 0, 0, 511, 0, 1);
    run_case(1, 0, 3, 256, 1, 1);
    run_case(1, 1, 2, 100, 0, 1);
    run_case(0, 0, 8191, 1, 0, 0);
    chk(cur_reload == 13'd8191, "R1 max reload stored", cur_reload, 8191);
    for (int i = 0; i < 10; i++) begin
      bit fr = 1'($urandom_range(0, 1));
      bit p3 = 1'($urandom_range(0, 1));
      int r = int'($urandom_range(0, 20));
      int fd = int'($urandom_range(64, 511));
      run_case(fr, p3, r, fd, 1'($urandom_range(0, 1)), 1);
    end
    ctl(1'b0, 0, 0);
    begin
      int seen = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (ovs_tick || bit_tick) seen++;
      end
      chk(seen == 0, "R8 no strobes while stopped", seen, 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule